// File: doc/BRIEF.md
# Set/Clear Bit-Bang Two-Wire Port

This peripheral gives software direct control of a two-wire serial bus, one clock line and one data line, by flipping bits in a register. There is no protocol engine behind it. Software builds start conditions, data bits, acknowledges and stop conditions by itself, one register write at a time. A 2-bit output latch holds the wanted level of each line. Bit 0 is the clock line and bit 1 is the data line.

The latch is never written directly. One word address ORs ones into it, and a second word address clears the bits marked by ones. Both lines are open-drain. A latch bit of 1 releases the pad so the external pull-up takes it high, and a latch bit of 0 enables the low driver.

A read returns the driven clock bit and the data line as it is actually seen on the bus. That level passes through a synchronizer first, so another device holding the line low, such as a target driving an acknowledge, shows up in the read data. The window covers 4 KiB, which is 1024 word addresses. A read of any word other than the first returns all ones.

Top module: `twl_bitbang_port`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the latch is 2'b11, both pad enables are 0 (released) and the read data is zero.
- R2: A write to word index 0 ORs write-data bits [1:0] into the latch on the next clock edge. Write-data bits above bit 1 have no effect.
- R3: A write to word index 1 clears each latch bit whose write-data bit is 1. Write-data bits above bit 1 have no effect.
- R4: A write to any word index other than 0 or 1 leaves both pad enables unchanged.
- R5: A read of word index 0 returns, one clock after the read strobe, latch bit 0 in bit 0 and the synchronized data-line level in bit 1, with all higher bits zero.
- R6: A read of any word index other than 0 returns all ones one clock after the strobe.
- R7: The clock pad enable is the inverse of latch bit 0 and the data pad enable is the inverse of latch bit 1. Both change in the cycle after the write strobe.
- R8: The data-line input passes through SYNC_STAGES flops. A read strobed fewer than SYNC_STAGES cycles after an input change returns the old level, and a read strobed exactly SYNC_STAGES cycles after it returns the new level.
- R9: When a read and a write of word index 0 come in the same cycle, the read returns the latch value from before the write.
- R10: Read data holds its value in every cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W (10) | Word index within the 4 KiB window |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Registered read data |
| scl_oe | output | 1 | Clock pad low-drive enable (1 pulls the line low) |
| sda_oe | output | 1 | Data pad low-drive enable (1 pulls the line low) |
| sda_in | input | 1 | Data pad input level (asynchronous) |

## Verification
The bench builds the block with SYNC_STAGES set to 3 instead of the default 2, with ADDR_W and DATA_W at their defaults. The deeper chain gives the latency test room to place reads strobed 0, 1 and 2 cycles after a data-line change, which must return the old level, and a read strobed 3 cycles after it, which must return the new level. That way an off-by-one stage count shows up in the read data. The full 10-bit index lets the bench reach the top word 0x3FF for both ignored writes and all-ones reads. The bench models the open-drain bus, so a released data line that is held low externally must read back as 0.

// File: rtl/twl_pkg.sv
package twl_pkg;

    localparam int NUM_LINES = 2;
    localparam int LINE_CLK  = 0;
    localparam int LINE_DAT  = 1;

    typedef logic [NUM_LINES-1:0] line_vec_t;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_SET   = 2'd1,
        ACC_CLR   = 2'd2,
        ACC_OTHER = 2'd3
    } wr_kind_e;

    localparam line_vec_t LINES_IDLE = '1;

endpackage

// File: rtl/twl_addr_decode.sv
module twl_addr_decode #(
    parameter int ADDR_W = 10
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output twl_pkg::wr_kind_e wr_kind,
    output logic              rd_hit
);
    import twl_pkg::*;

    localparam logic [ADDR_W-1:0] IDX_SET = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] IDX_CLR = ADDR_W'(1);

    always_comb begin
        rd_hit = (addr == IDX_SET);
        if (!wr_en) begin
            wr_kind = ACC_NONE;
        end else if (addr == IDX_SET) begin
            wr_kind = ACC_SET;
        end else if (addr == IDX_CLR) begin
            wr_kind = ACC_CLR;
        end else begin
            wr_kind = ACC_OTHER;
        end
    end

endmodule

// File: rtl/twl_line_latch.sv
module twl_line_latch (
    input  logic               clk,
    input  logic               rst_n,
    input  twl_pkg::wr_kind_e  wr_kind,
    input  twl_pkg::line_vec_t wbits,
    output twl_pkg::line_vec_t lines_q
);
    import twl_pkg::*;

    typedef struct packed {
        line_vec_t lines;
    } latch_state_t;

    latch_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        unique case (wr_kind)
            ACC_SET: state_d.lines = state_q.lines | wbits;
            ACC_CLR: state_d.lines = state_q.lines & ~wbits;
            default: state_d.lines = state_q.lines;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.lines <= LINES_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign lines_q = state_q.lines;

endmodule

// File: rtl/twl_sync.sv
module twl_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_state_t;

    sync_state_t state_d, state_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb begin
                state_d       = state_q;
                state_d.chain = din;
            end
        end else begin : g_multi
            always_comb begin
                state_d       = state_q;
                state_d.chain = {state_q.chain[STAGES-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.chain <= {STAGES{RESET_VAL}};
        end else begin
            state_q <= state_d;
        end
    end

    assign dout = state_q.chain[STAGES-1];

endmodule

// File: rtl/twl_read_port.sv
module twl_read_port #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              rd_hit,
    input  logic              clk_bit,
    input  logic              dat_bit,
    output logic [DATA_W-1:0] rdata_q
);
    localparam int PAD_W = DATA_W - 2;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_state_t;

    rd_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (rd_en) begin
            if (rd_hit) begin
                state_d.rdata = {{PAD_W{1'b0}}, dat_bit, clk_bit};
            end else begin
                state_d.rdata = '1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.rdata <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rdata_q = state_q.rdata;

endmodule

// File: rtl/twl_bitbang_port.sv
module twl_bitbang_port #(
    parameter int ADDR_W      = 10,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic              sda_in
);
    import twl_pkg::*;

    localparam int USED_W = NUM_LINES;

    wr_kind_e  wr_kind;
    logic      rd_hit;
    line_vec_t lines_q;
    line_vec_t wbits;
    logic      sda_sync;
    logic      unused_wdata_hi;

    assign wbits           = wdata[USED_W-1:0];
    assign unused_wdata_hi = ^wdata[DATA_W-1:USED_W];

    twl_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_kind (wr_kind),
        .rd_hit  (rd_hit)
    );

    twl_line_latch u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_kind (wr_kind),
        .wbits   (wbits),
        .lines_q (lines_q)
    );

    twl_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (sda_in),
        .dout  (sda_sync)
    );

    twl_read_port #(.DATA_W(DATA_W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_hit  (rd_hit),
        .clk_bit (lines_q[LINE_CLK]),
        .dat_bit (sda_sync),
        .rdata_q (rdata)
    );

    // open-drain: a latch bit of 0 enables the low driver
    assign scl_oe = ~lines_q[LINE_CLK];
    assign sda_oe = ~lines_q[LINE_DAT];

endmodule

// File: rtl/twl_bitbang_port_chk.sv
module twl_bitbang_port_chk #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [1:0]        wset,
    input logic [DATA_W-1:0] rdata,
    input logic              scl_oe,
    input logic              sda_oe
);
    localparam logic [ADDR_W-1:0] I0 = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] I1 = ADDR_W'(1);

    // R1
    a_r1_reset_idle: assert property (@(posedge clk)
        $rose(rst_n) |-> (!scl_oe && !sda_oe && rdata == '0));

    // R2
    a_r2_set_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == I0 && wset == 2'b11) |=> (!scl_oe && !sda_oe));

    // R2: a set with zero low bits changes nothing
    a_r2_set_zero_noop: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == I0 && wset == 2'b00) |=> ($stable(scl_oe) && $stable(sda_oe)));

    // R3
    a_r3_clear_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == I1 && wset == 2'b11) |=> (scl_oe && sda_oe));

    // R4
    a_r4_other_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr != I0 && addr != I1) |=> ($stable(scl_oe) && $stable(sda_oe)));

    // R7
    a_r7_no_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(scl_oe) && $stable(sda_oe)));

    // R5 and R9: bit 0 carries the pre-write clock latch bit
    a_r5_read_layout: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == I0) |=> (rdata[0] == !$past(scl_oe) && rdata[DATA_W-1:2] == '0));

    // R6
    a_r6_bad_read_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr != I0) |=> (rdata == '1));

    // R10
    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

endmodule

bind twl_bitbang_port twl_bitbang_port_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_en  (rd_en),
    .wr_en  (wr_en),
    .addr   (addr),
    .wset   (wdata[1:0]),
    .rdata  (rdata),
    .scl_oe (scl_oe),
    .sda_oe (sda_oe)
);

// File: tb/twl_bitbang_port_test.sv
module twl_bitbang_port_test;

    localparam int ADDR_W = 10;
    localparam int DATA_W = 32;
    localparam int SYNC   = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rd_en = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic              scl_oe;
    logic              sda_oe;
    logic              sda_in;
    logic              ext_sda = 1'b1;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [1:0]        m_lat = 2'b11;
    logic [DATA_W-1:0] exp_q[$];
    string             tag_q[$];

    always #5 clk = ~clk;

    // open-drain bus model with an external device on the data line
    assign sda_in = sda_oe ? 1'b0 : ext_sda;

    twl_bitbang_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC)) uut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in)
    );

    task automatic check(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] rd_exp();
        return {{(DATA_W-2){1'b0}}, (m_lat[1] & ext_sda), m_lat[0]};
    endfunction

    // monitor: compares rdata one clock after each read strobe
    initial begin
        forever begin
            @(posedge clk);
            if (rd_en && rst_n) begin
                #1;
                if (exp_q.size() == 0) begin
                    check("R5 unexpected read", rdata, '0);
                end else begin
                    check(tag_q.pop_front(), rdata, exp_q.pop_front());
                end
            end
        end
    end

    task automatic settle();
        repeat (SYNC + 1) @(negedge clk);
    endtask

    task automatic do_write(input logic [ADDR_W-1:0] idx, input logic [DATA_W-1:0] d, input string tag);
        @(negedge clk);
        wr_en = 1'b1; addr = idx; wdata = d;
        if (idx == 0) m_lat = m_lat | d[1:0];
        else if (idx == 1) m_lat = m_lat & ~d[1:0];
        @(negedge clk);
        wr_en = 1'b0;
        check({tag, " R7 scl_oe"}, {31'b0, scl_oe}, {31'b0, ~m_lat[0]});
        check({tag, " R7 sda_oe"}, {31'b0, sda_oe}, {31'b0, ~m_lat[1]});
        settle();
    endtask

    task automatic do_read(input logic [ADDR_W-1:0] idx, input string tag);
        @(negedge clk);
        exp_q.push_back(idx == 0 ? rd_exp() : '1);
        tag_q.push_back(tag);
        rd_en = 1'b1; addr = idx;
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [DATA_W-1:0] held;
        repeat (3) @(negedge clk);
        check("R1 scl_oe in reset", {31'b0, scl_oe}, '0);
        check("R1 sda_oe in reset", {31'b0, sda_oe}, '0);
        check("R1 rdata in reset", rdata, '0);
        rst_n = 1'b1;
        settle();
        check("R1 rdata after reset", rdata, '0);

        do_read(0, "R5 idle read");
        do_write(1, 32'h1, "R3 clear clk");
        do_read(0, "R5 clk low");
        do_write(1, 32'h2, "R3 clear data");
        do_read(0, "R5 data driven low");
        do_write(0, 32'hFFFF_FFFC, "R2 high bits only");
        do_write(0, 32'h1, "R2 set clk");
        do_read(0, "R2 after clk set");
        do_write(0, 32'h2, "R2 set data");
        do_read(0, "R2 after data set");
        do_write(1, 32'hFFFF_FFFC, "R3 high bits only");

        // external device holds the released data line low
        ext_sda = 1'b0; settle();
        do_read(0, "R8 external pull low");
        ext_sda = 1'b1; settle();

        do_write(1, 32'h3, "R3 clear both");
        do_write(2, 32'h3, "R4 index 2");
        do_write(10'h3FF, 32'h3, "R4 index 3ff");
        do_read(0, "R4 latch still low");
        do_write(0, 32'h3, "R2 set both");

        do_read(1, "R6 index 1");
        do_read(10'h3FF, "R6 index 3ff");
        held = rdata;
        repeat (4) @(negedge clk);
        check("R10 rdata hold", rdata, held);

        // R8: input change seen only after SYNC stages
        @(negedge clk);
        ext_sda = 1'b0;
        for (int k = 0; k <= SYNC; k++) begin
            exp_q.push_back(k < SYNC ? 32'h3 : 32'h1);
            tag_q.push_back($sformatf("R8 read %0d cycles after change", k));
            rd_en = 1'b1; addr = 0;
            @(negedge clk);
        end
        rd_en = 1'b0;
        ext_sda = 1'b1;
        settle();

        // R9: read and set write in the same cycle
        do_write(1, 32'h1, "R9 prep clk low");
        @(negedge clk);
        exp_q.push_back(rd_exp());
        tag_q.push_back("R9 read sees pre-write latch");
        rd_en = 1'b1; wr_en = 1'b1; addr = 0; wdata = 32'h1;
        m_lat = m_lat | 2'b01;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        check("R9 clk released after write", {31'b0, scl_oe}, '0);
        settle();
        do_read(0, "R9 follow-up read");

        repeat (3) @(negedge clk);
        check("R5 scoreboard drained", 32'(exp_q.size()), '0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule